// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo audio from a three-wire serial link (a bit clock, a word clock that marks the channel, and a data line). It turns the link into parallel 18-bit signed samples for the left and right channels. The block runs entirely on the master clock. It passes the three serial lines through two-stage synchronizers and finds bit-clock edges by oversampling, so the serial clocks never clock any flip-flop.

A two-bit strap selects one of four framings. Two are right-justified, with 16-bit or 18-bit words. One is left-justified and captures data on the falling edge of the bit clock. One is I2S. A single shift engine serves all four framings. Every word-clock transition closes the half-frame that came before it, and the sample of that half-frame appears on its channel's output with a one-cycle valid strobe.

A 16-bit word is placed in the upper bits of the 18-bit output, and its two lowest bits are zero. The strap is static: change it only while reset is held.

Top module: `ser_audio_rx`

## Requirements
- R1: `fmtSel` selects the framing, where `fmtSel[1]` is the high bit of the code:
  - 2'b00: right-justified 16-bit, captured on the rising edge.
  - 2'b01: right-justified 18-bit, captured on the rising edge.
  - 2'b10: left-justified, captured on the falling edge.
  - 2'b11: I2S, captured on the rising edge.
- R2: Data arrives MSB first in two's complement. A 16-bit word appears on output bits 17:2, and output bits 1:0 are zero. The word is not sign-extended into the low bits.
- R3: In code 00, the sample is the last 16 bits captured on rising edges before the word-clock transition. Word clock high marks the left channel.
- R4: In code 01, the sample is the last 18 bits captured on rising edges before the word-clock transition. Word clock high marks the left channel.
- R5: In code 10, the MSB is the bit captured on the first falling edge that sees the new word-clock level. The next 17 falling edges supply the rest of the 18 bits, and any later bits in the half-frame are ignored. Word clock high marks the left channel.
- R6: In code 11, the bit on the first rising edge after the transition is ignored. The following 18 rising edges supply the word, MSB first, and word clock low marks the left channel.
- R7: Codes 00 and 10 also work when each half-frame has only 16 bit-clock periods. In code 10, the 16 bits received become output bits 17:2, and bits 1:0 are zero.
- R8: A half-frame's sample is presented on the capture edge that ends the half-frame, with a single-cycle valid pulse on that channel only. Left and right pulses never coincide, and each data output holds its value between its pulses.
- R9: During and after reset, both data outputs are zero and both valid outputs are low. The half-frame that is running when the first transition is seen produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 2 | Framing select strap |
| bitClk | input | 1 | Serial bit clock (asynchronous) |
| wordClk | input | 1 | Serial word/channel clock (asynchronous) |
| serData | input | 1 | Serial data |
| leftData | output | 18 | Left-channel sample, signed |
| leftValid | output | 1 | One-cycle strobe for a new left sample |
| rightData | output | 18 | Right-channel sample, signed |
| rightValid | output | 1 | One-cycle strobe for a new right sample |

## Verification
The bench sweeps every framing with 32-clock half-frames, and sweeps codes 00 and 10 with 16-clock half-frames. The words cover both signs, the extremes and alternating bit patterns. The bits outside each word are filled with toggling values, so a window that is off by one bit would take in a stray bit or drop the LSB. An I2S receiver that forgot the one-bit delay would show up as a left shift, and one with the wrong channel polarity would swap left and right. A short left-justified frame that was sign-extended, or one that took in bits beyond the 18th, would corrupt bits 1:0. Stray strobes during the discarded first half-frame, or a missing strobe on the last one, break the per-channel sample counts.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int WORD_W  = 18;
  parameter int SHORT_W = 16;
  localparam int PAD_W  = WORD_W - SHORT_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ18 = 2'b01,
    FMT_LJ   = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic             capture;
    logic             frameEdge;
    logic             emitLeft;
    logic             emitRight;
    logic             bitVal;
    logic             ljWr;
    logic [CNT_W-1:0] ljIdx;
  } ctrl_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  fmt_e  fmt,
  input  logic  bitClk,
  input  logic  wordClk,
  input  logic  serData,
  output ctrl_t ctrl
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] WORD_C  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [2:0] bckS;
  logic [1:0] wckS;
  logic [1:0] datS;
  logic seen, lastWc, armed;
  logic [CNT_W-1:0] pos;

  logic rise, fall, capture, frameEdge, emit, leftLevel, isI2s;
  logic [CNT_W-1:0] slot, dataIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bckS <= '0;
      wckS <= '0;
      datS <= '0;
    end else begin
      bckS <= {bckS[1:0], bitClk};
      wckS <= {wckS[0], wordClk};
      datS <= {datS[0], serData};
    end
  end

  always_comb begin
    rise      = bckS[1] & ~bckS[2];
    fall      = ~bckS[1] & bckS[2];
    capture   = (fmt == FMT_LJ) ? fall : rise;
    frameEdge = capture && seen && (wckS[1] != lastWc);
    emit      = frameEdge && armed;
    isI2s     = (fmt == FMT_I2S);
    leftLevel = !isI2s;
    slot      = frameEdge ? '0 : pos;
    dataIdx   = isI2s ? (slot - ONE_C) : slot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seen   <= 1'b0;
      lastWc <= 1'b0;
      armed  <= 1'b0;
      pos    <= '0;
    end else if (capture) begin
      seen   <= 1'b1;
      lastWc <= wckS[1];
      if (frameEdge) begin
        armed <= 1'b1;
        pos   <= ONE_C;
      end else if (pos != CNT_MAX) begin
        pos <= pos + ONE_C;
      end
    end
  end

  always_comb begin
    ctrl.capture   = capture;
    ctrl.frameEdge = frameEdge;
    ctrl.emitLeft  = emit && (lastWc == leftLevel);
    ctrl.emitRight = emit && (lastWc != leftLevel);
    ctrl.bitVal    = datS[1];
    if (isI2s) ctrl.ljWr = capture && (slot != '0) && (slot <= WORD_C);
    else       ctrl.ljWr = capture && (slot < WORD_C);
    ctrl.ljIdx     = LAST_C - dataIdx;
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fmt_e              fmt,
  input  ctrl_t             ctrl,
  output logic [WORD_W-1:0] leftData,
  output logic              leftValid,
  output logic [WORD_W-1:0] rightData,
  output logic              rightValid
);
  logic [WORD_W-1:0] shReg, ljWord, ljNext, doneWord;
  logic [WORD_W-1:0] chData  [2];
  logic              chValid [2];

  always_comb begin
    ljNext = ctrl.frameEdge ? '0 : ljWord;
    if (ctrl.ljWr) ljNext[ctrl.ljIdx] = ctrl.bitVal;
  end

  always_comb begin
    unique case (fmt)
      FMT_RJ16: doneWord = {shReg[SHORT_W-1:0], {PAD_W{1'b0}}};
      FMT_RJ18: doneWord = shReg;
      default:  doneWord = ljWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      ljWord <= '0;
    end else if (ctrl.capture) begin
      shReg  <= {shReg[WORD_W-2:0], ctrl.bitVal};
      ljWord <= ljNext;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic emitCh;
    assign emitCh = (ch == 0) ? ctrl.emitLeft : ctrl.emitRight;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chData[ch]  <= '0;
        chValid[ch] <= 1'b0;
      end else begin
        chValid[ch] <= emitCh;
        if (emitCh) chData[ch] <= doneWord;
      end
    end
  end

  assign leftData   = chData[0];
  assign leftValid  = chValid[0];
  assign rightData  = chData[1];
  assign rightValid = chValid[1];
endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fmtSel,
  input  logic              bitClk,
  input  logic              wordClk,
  input  logic              serData,
  output logic [WORD_W-1:0] leftData,
  output logic              leftValid,
  output logic [WORD_W-1:0] rightData,
  output logic              rightValid
);
  fmt_e  fmt;
  ctrl_t ctrl;

  assign fmt = fmt_e'(fmtSel);

  sar_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .fmt(fmt), .bitClk(bitClk),
    .wordClk(wordClk), .serData(serData), .ctrl(ctrl)
  );

  sar_datapath i_dp (
    .clk(clk), .rstN(rstN), .fmt(fmt), .ctrl(ctrl),
    .leftData(leftData), .leftValid(leftValid),
    .rightData(rightData), .rightValid(rightValid)
  );
endmodule

// File: rtl/sar_checker.sv
module sar_checker
  import sar_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        fmtSel,
  input logic [WORD_W-1:0] leftData,
  input logic              leftValid,
  input logic [WORD_W-1:0] rightData,
  input logic              rightValid
);
  logic lastLeft, anySeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLeft <= 1'b0;
      anySeen  <= 1'b0;
    end else if (leftValid || rightValid) begin
      lastLeft <= leftValid;
      anySeen  <= 1'b1;
    end
  end

  // R8
  valid_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && rightValid));

  // R8
  left_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |=> !leftValid);

  // R8
  right_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rightValid |=> !rightValid);

  // R8
  left_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !leftValid |-> $stable(leftData));

  // R8
  right_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rightValid |-> $stable(rightData));

  // R8
  alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anySeen && (leftValid || rightValid)) |-> (leftValid != lastLeft));

  // R2
  short_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel == 2'b00 && (leftValid || rightValid)) |->
      (leftData[1:0] == 2'b00 && rightData[1:0] == 2'b00));
endmodule

bind ser_audio_rx sar_checker i_sar_checker (
  .clk(clk), .rstN(rstN), .fmtSel(fmtSel),
  .leftData(leftData), .leftValid(leftValid),
  .rightData(rightData), .rightValid(rightValid)
);

// File: tb/test_ser_audio_rx.sv
module test_ser_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCK   = 4;
  localparam int MAXF       = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] fmtSel = 2'b00;
  logic bitClk = 1'b0, wordClk = 1'b0, serData = 1'b0;
  logic [17:0] leftData, rightData;
  logic leftValid, rightValid;

  int total = 0, bad = 0;
  logic [17:0] expL [MAXF];
  logic [17:0] expR [MAXF];
  int idxL = 0, idxR = 0, nExp = 0;
  string tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_audio_rx i_ser_audio_rx (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .bitClk(bitClk),
    .wordClk(wordClk), .serData(serData), .leftData(leftData),
    .leftValid(leftValid), .rightData(rightData), .rightValid(rightValid)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: each strobe delivers the next expected sample of its channel
  always @(negedge clk) begin
    if (rstN && leftValid) begin
      if (idxL < nExp) check({tag, " left"}, leftData, expL[idxL]);
      else check("R9 stray left strobe", 18'h1, 18'h0);
      idxL++;
    end
    if (rstN && rightValid) begin
      if (idxR < nExp) check({tag, " right"}, rightData, expR[idxR]);
      else check("R9 stray right strobe", 18'h1, 18'h0);
      idxR++;
    end
  end

  function automatic logic [17:0] wordOf(input int k, input int ch);
    logic [17:0] v;
    case (k)
      0: v = 18'h1FFFF;
      1: v = 18'h20000;
      2: v = 18'h3FFFF;
      3: v = 18'h00001;
      4: v = 18'h2AAAA;
      5: v = 18'h15554;
      6: v = 18'h3FFFC;
      default: v = 18'((k * 32'h0B3C5) + (ch * 32'h1D2E7) + 32'h00123);
    endcase
    if (ch == 1) v = ~v;
    return v;
  endfunction

  task automatic sendHalf(input int mode, input bit isLeft, input logic [17:0] w, input int halfBits);
    bit idle = (mode == 2);
    bit lvl = (mode == 3) ? !isLeft : isLeft;
    for (int p = 0; p < halfBits; p++) begin
      bit b = p[0] ^ isLeft;
      case (mode)
        0: if (p >= halfBits - 16) b = w[17 - (p - (halfBits - 16))];
        1: if (p >= halfBits - 18) b = w[17 - (p - (halfBits - 18))];
        2: if (p < 18) b = w[17 - p];
        default: if (p >= 1 && p <= 18) b = w[18 - p];
      endcase
      @(negedge clk);
      bitClk = idle; wordClk = lvl; serData = b;
      repeat (HALF_BCK) @(negedge clk);
      bitClk = ~idle;
      repeat (HALF_BCK) @(negedge clk);
      bitClk = idle;
    end
  endtask

  task automatic runBlock(input int mode, input int halfBits, input int frames);
    bit isShort = (halfBits == 16);
    case (mode)
      0: tag = isShort ? "R7 mode00" : "R3 mode00";
      1: tag = "R4 mode01";
      2: tag = isShort ? "R7 mode10" : "R5 mode10";
      default: tag = "R6 mode11";
    endcase
    rstN = 1'b0;
    fmtSel = 2'(mode);
    bitClk = (mode == 2);
    wordClk = (mode == 3);
    serData = 1'b0;
    nExp = frames;
    idxL = 0; idxR = 0;
    for (int f = 0; f < frames; f++) begin
      logic [17:0] l = wordOf(f, 0);
      logic [17:0] r = wordOf(f, 1);
      // R1 R2: 16-bit paths land in bits 17:2 with zero low bits
      if (mode == 0 || (mode == 2 && isShort)) begin
        l[1:0] = 2'b00; r[1:0] = 2'b00;
      end
      expL[f] = l; expR[f] = r;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset leftData", leftData, 18'h0);
    check("R9 reset rightData", rightData, 18'h0);
    check("R9 reset valids", {16'h0, leftValid, rightValid}, 18'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    sendHalf(mode, 1'b0, 18'h2D2D2, halfBits);
    for (int f = 0; f < frames; f++) begin
      sendHalf(mode, 1'b1, expL[f], halfBits);
      sendHalf(mode, 1'b0, expR[f], halfBits);
    end
    sendHalf(mode, 1'b1, 18'h12345, halfBits);
    repeat (20) @(negedge clk);
    // R8 R9: one strobe per finished half-frame, none for the lead-in
    check({tag, " R8 left count"}, 18'(idxL), 18'(frames));
    check({tag, " R8 right count"}, 18'(idxR), 18'(frames));
  endtask

  initial begin
    runBlock(0, 32, 8);
    runBlock(1, 32, 8);
    runBlock(2, 32, 8);
    runBlock(3, 32, 8);
    runBlock(0, 16, 6);
    runBlock(2, 16, 6);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule